// File: doc/BRIEF.md
# Checksummed Command Line Receiver

This block sits behind a UART receiver that has already turned the serial stream into bytes. Each received byte arrives with a one-cycle valid flag. The block builds text command lines out of these bytes. A line is a command name, then a colon, then two hexadecimal characters. Those two characters carry an 8-bit additive checksum of the name. When the line feed arrives, the block compares the low eight bits of the sum of the name bytes with the hex value it received.

A line that passes raises a one-cycle command strobe. The captured name and its length are held on the outputs until the next good line. A line that fails for any reason raises a one-cycle error strobe instead. The error carries a fixed error code, plus a flag that marks a name too long for the buffer. All line state is cleared at every line feed, so each line is judged on its own.

Top module: `chk_cmd_rx`

## Requirements
- R1: A byte is consumed only in a cycle where `rxValid` is high. The value on `rxData` in any other cycle has no effect.
- R2: A line made of a name, a colon (0x3A) and two hex digits is accepted when the digits equal the sum of the name bytes modulo 256. `cmdValid` is then high in the cycle after the cycle in which the terminating byte is accepted.
- R3: On acceptance, name character k (the first received is k = 0) appears on `cmdName[8k+7:8k]`, and positions past the name read zero. `cmdLen` gives the number of name characters. Both outputs hold their values until the next accepted line.
- R4: Hex digits 0-9, A-F and a-f are all accepted. Any other character after the colon, including a second colon, makes the line an error.
- R5: A line with a checksum mismatch raises `errValid` in the cycle after its terminator. `errCode` equals 0xF0000002 while `errValid` is high and is zero otherwise.
- R6: A line with no colon, or with a number of hex digits other than two, is reported as an error, not accepted.
- R7: A name longer than NAME_MAX (default 16) characters gives an error with `errOverflow` high for that error cycle. A name of exactly NAME_MAX characters is accepted.
- R8: A line feed (0x0A) ends a line whether or not a carriage return came before it. A carriage return (0x0D) anywhere in a line is dropped: it is neither stored nor summed.
- R9: `cmdValid` and `errValid` are single-cycle strobes. They are never high together, and each follows only a cycle that accepted a line feed.
- R10: The name buffer, the running sum, the hash field and all error conditions are cleared at each line feed and at reset. The outcome of one line therefore never affects the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxValid | input | 1 | A received byte is present on `rxData` |
| rxData | input | 8 | Received byte |
| cmdValid | output | 1 | One-cycle strobe: a line was accepted |
| cmdName | output | NAME_MAX*8 | Captured name, first character in the low byte |
| cmdLen | output | $clog2(NAME_MAX+1) | Number of characters in the captured name |
| errValid | output | 1 | One-cycle strobe: a line was rejected |
| errOverflow | output | 1 | With `errValid`: the name exceeded the buffer |
| errCode | output | 32 | 0xF0000002 while `errValid` is high, else zero |

## Verification
Internal state in this block is seen at the ports only when a line feed arrives, so every fault shows up as a wrong verdict or a wrong name in the cycle right after the terminator. Each scenario uses a line built to land in one verdict case, so a fault in that case flips the strobe. The cases are a sum that carries past eight bits, a lowercase digit, a missing or extra digit, a name exactly at the buffer limit and one character past it, and a carriage return in the middle of a line. A clear that fails to happen at the end of a line only shows on the line after it. For that reason the error cases are each followed by a good line, and a long name is followed by a short one whose upper name bytes must read zero.

// File: rtl/chk_cmd_pkg.sv
package chk_cmd_pkg;

  localparam logic [7:0] CH_LF    = 8'h0A;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_COLON = 8'h3A;

  typedef enum logic {
    PH_NAME = 1'b0,
    PH_HASH = 1'b1
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       clearLine;
    logic       addName;
    logic       shiftHex;
    logic       markBad;
    logic       capture;
    logic [3:0] nibble;
    logic [7:0] dataByte;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic twoDigits;
    logic badDigit;
    logic overflow;
    logic sumMatch;
  } dpStatus_t;

endpackage

// File: rtl/chk_cmd_ctrl.sv
module chk_cmd_ctrl
  import chk_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic [7:0]  rxData,
  input  dpStatus_t   stat,
  output ctrlStrobe_t strb,
  output logic        cmdValid,
  output logic        errValid,
  output logic        errOverflow
);

  phase_e phase;
  logic   isLf, isCr, isColon, isHex;
  logic   [3:0] nib;
  logic   endLine, lineOk;

  // classify the incoming byte and decode a hex digit
  always_comb begin
    isLf    = (rxData == CH_LF);
    isCr    = (rxData == CH_CR);
    isColon = (rxData == CH_COLON);
    isHex   = 1'b0;
    nib     = 4'h0;
    if (rxData >= 8'h30 && rxData <= 8'h39) begin
      isHex = 1'b1;
      nib   = rxData[3:0];
    end else if ((rxData >= 8'h41 && rxData <= 8'h46) ||
                 (rxData >= 8'h61 && rxData <= 8'h66)) begin
      isHex = 1'b1;
      nib   = rxData[3:0] + 4'd9;
    end
  end

  always_comb begin
    endLine = rxValid && isLf;
    lineOk  = (phase == PH_HASH) && stat.twoDigits && !stat.badDigit &&
              !stat.overflow && stat.sumMatch;

    strb           = '0;
    strb.dataByte  = rxData;
    strb.nibble    = nib;
    strb.clearLine = endLine;
    strb.capture   = endLine && lineOk;
    strb.addName   = rxValid && (phase == PH_NAME) && !isLf && !isCr && !isColon;
    strb.shiftHex  = rxValid && (phase == PH_HASH) && isHex;
    strb.markBad   = rxValid && (phase == PH_HASH) && !isHex && !isLf && !isCr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_NAME;
    end else if (endLine) begin
      phase <= PH_NAME;
    end else if (rxValid && (phase == PH_NAME) && isColon) begin
      phase <= PH_HASH;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid    <= 1'b0;
      errValid    <= 1'b0;
      errOverflow <= 1'b0;
    end else begin
      cmdValid    <= endLine && lineOk;
      errValid    <= endLine && !lineOk;
      errOverflow <= endLine && !lineOk && stat.overflow;
    end
  end

endmodule

// File: rtl/chk_cmd_dp.sv
module chk_cmd_dp
  import chk_cmd_pkg::*;
#(
  parameter int NAME_MAX = 16,
  localparam int LEN_W   = $clog2(NAME_MAX + 1)
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strb,
  output dpStatus_t               stat,
  output logic [NAME_MAX*8-1:0]   cmdName,
  output logic [LEN_W-1:0]        cmdLen
);

  logic [NAME_MAX-1:0][7:0] nameBuf;
  logic [NAME_MAX-1:0][7:0] nameHold;
  logic [LEN_W-1:0]         nameLen;
  logic [7:0]               sumAcc;
  logic [7:0]               hashVal;
  logic [1:0]               hashCnt;
  logic                     badDigit;
  logic                     overflow;
  logic                     bufFull;

  assign bufFull = (nameLen == LEN_W'(NAME_MAX));

  // one storage slot per name position
  for (genvar i = 0; i < NAME_MAX; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        nameBuf[i] <= 8'h00;
      end else if (strb.clearLine) begin
        nameBuf[i] <= 8'h00;
      end else if (strb.addName && (nameLen == LEN_W'(i))) begin
        nameBuf[i] <= strb.dataByte;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nameLen  <= '0;
      sumAcc   <= 8'h00;
      overflow <= 1'b0;
    end else if (strb.clearLine) begin
      nameLen  <= '0;
      sumAcc   <= 8'h00;
      overflow <= 1'b0;
    end else if (strb.addName) begin
      sumAcc <= sumAcc + strb.dataByte;
      if (bufFull) overflow <= 1'b1;
      else         nameLen  <= nameLen + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hashVal  <= 8'h00;
      hashCnt  <= 2'd0;
      badDigit <= 1'b0;
    end else if (strb.clearLine) begin
      hashVal  <= 8'h00;
      hashCnt  <= 2'd0;
      badDigit <= 1'b0;
    end else begin
      if (strb.shiftHex) begin
        hashVal <= {hashVal[3:0], strb.nibble};
        if (hashCnt != 2'd3) hashCnt <= hashCnt + 2'd1;
      end
      if (strb.markBad) badDigit <= 1'b1;
    end
  end

  // result registers, loaded only for an accepted line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nameHold <= '0;
      cmdLen   <= '0;
    end else if (strb.capture) begin
      nameHold <= nameBuf;
      cmdLen   <= nameLen;
    end
  end

  assign cmdName = nameHold;

  always_comb begin
    stat.twoDigits = (hashCnt == 2'd2);
    stat.badDigit  = badDigit;
    stat.overflow  = overflow;
    stat.sumMatch  = (hashVal == sumAcc);
  end

endmodule

// File: rtl/chk_cmd_rx.sv
module chk_cmd_rx
  import chk_cmd_pkg::*;
#(
  parameter int          NAME_MAX = 16,
  parameter logic [31:0] ERR_CODE = 32'hF000_0002,
  localparam int         LEN_W    = $clog2(NAME_MAX + 1)
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rxValid,
  input  logic [7:0]            rxData,
  output logic                  cmdValid,
  output logic [NAME_MAX*8-1:0] cmdName,
  output logic [LEN_W-1:0]      cmdLen,
  output logic                  errValid,
  output logic                  errOverflow,
  output logic [31:0]           errCode
);

  ctrlStrobe_t strb;
  dpStatus_t   stat;

  chk_cmd_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .rxValid     (rxValid),
    .rxData      (rxData),
    .stat        (stat),
    .strb        (strb),
    .cmdValid    (cmdValid),
    .errValid    (errValid),
    .errOverflow (errOverflow)
  );

  chk_cmd_dp #(.NAME_MAX(NAME_MAX)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .stat    (stat),
    .cmdName (cmdName),
    .cmdLen  (cmdLen)
  );

  assign errCode = errValid ? ERR_CODE : 32'h0;

endmodule

// File: rtl/chk_cmd_rx_sva.sv
module chk_cmd_rx_sva #(
  parameter int          NAME_MAX = 16,
  parameter logic [31:0] ERR_CODE = 32'hF000_0002,
  localparam int         LEN_W    = $clog2(NAME_MAX + 1)
)(
  input logic                  clk,
  input logic                  rstN,
  input logic                  rxValid,
  input logic [7:0]            rxData,
  input logic                  cmdValid,
  input logic [NAME_MAX*8-1:0] cmdName,
  input logic [LEN_W-1:0]      cmdLen,
  input logic                  errValid,
  input logic                  errOverflow,
  input logic [31:0]           errCode
);

  logic lfIn;
  assign lfIn = rxValid && (rxData == 8'h0A);

  AST_LF_GIVES_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
    lfIn |=> (cmdValid || errValid)); // R2

  AST_NAME_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !lfIn |=> ($stable(cmdName) && $stable(cmdLen))); // R3

  AST_ERR_CODE: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> (errCode == ERR_CODE)); // R5

  AST_NO_CODE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !errValid |-> (errCode == 32'h0)); // R5

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cmdLen <= LEN_W'(NAME_MAX)); // R7

  AST_OVERFLOW_IS_ERR: assert property (@(posedge clk) disable iff (!rstN)
    errOverflow |-> errValid); // R7

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && errValid)); // R9

  AST_STROBE_AFTER_LF: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid || errValid) |-> $past(lfIn)); // R9

endmodule

bind chk_cmd_rx chk_cmd_rx_sva #(.NAME_MAX(NAME_MAX), .ERR_CODE(ERR_CODE)) uSva (
  .clk         (clk),
  .rstN        (rstN),
  .rxValid     (rxValid),
  .rxData      (rxData),
  .cmdValid    (cmdValid),
  .cmdName     (cmdName),
  .cmdLen      (cmdLen),
  .errValid    (errValid),
  .errOverflow (errOverflow),
  .errCode     (errCode)
);

// File: tb/tb_chk_cmd_rx.sv
module tb_chk_cmd_rx;

  localparam int NAME_MAX = 16;
  localparam int LEN_W    = $clog2(NAME_MAX + 1);

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  rxValid = 1'b0;
  logic [7:0]            rxData = 8'h00;
  logic                  cmdValid;
  logic [NAME_MAX*8-1:0] cmdName;
  logic [LEN_W-1:0]      cmdLen;
  logic                  errValid;
  logic                  errOverflow;
  logic [31:0]           errCode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  chk_cmd_rx #(.NAME_MAX(NAME_MAX)) dut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .cmdValid(cmdValid), .cmdName(cmdName), .cmdLen(cmdLen),
    .errValid(errValid), .errOverflow(errOverflow), .errCode(errCode)
  );

  task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] sumOf(string s);
    logic [7:0] acc = 8'h00;
    for (int k = 0; k < s.len(); k++) acc = acc + 8'(s[k]);
    return acc;
  endfunction

  function automatic logic [127:0] packName(string s);
    logic [127:0] v = '0;
    for (int k = 0; k < s.len() && k < NAME_MAX; k++) v[8*k +: 8] = 8'(s[k]);
    return v;
  endfunction

  task automatic sendByte(logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1;
    rxData  = b;
    @(negedge clk);
    rxValid = 1'b0;
    rxData  = 8'hA5;
  endtask

  // send raw text; returns at the negedge right after the last byte's edge
  task automatic sendText(string s);
    for (int k = 0; k < s.len(); k++) sendByte(8'(s[k]));
  endtask

  task automatic expectCmd(string req, string name);
    check(req, "cmdValid", 128'(cmdValid), 128'd1);
    check(req, "errValid", 128'(errValid), 128'd0);
    check(req, "cmdLen", 128'(cmdLen), 128'(name.len()));
    check(req, "cmdName", 128'(cmdName), packName(name));
    @(negedge clk);
    check("R9", "cmdValid one cycle", 128'(cmdValid), 128'd0);
  endtask

  task automatic expectErr(string req, bit ovf);
    check(req, "errValid", 128'(errValid), 128'd1);
    check(req, "cmdValid", 128'(cmdValid), 128'd0);
    check("R5", "errCode", 128'(errCode), 128'hF000_0002);
    check(req, "errOverflow", 128'(errOverflow), 128'(ovf));
    @(negedge clk);
    check("R9", "errValid one cycle", 128'(errValid), 128'd0);
    check("R5", "errCode idle", 128'(errCode), 128'd0);
  endtask

  task automatic testReset();
    check("R10", "reset cmdValid", 128'(cmdValid), 128'd0);
    check("R10", "reset errValid", 128'(errValid), 128'd0);
    check("R10", "reset cmdLen", 128'(cmdLen), 128'd0);
    check("R10", "reset cmdName", 128'(cmdName), 128'd0);
  endtask

  task automatic testGoodUpper();
    // VER sums to 0xED
    check("R2", "VER sum", 128'(sumOf("VER")), 128'hED);
    sendText({"VER:", $sformatf("%02X", sumOf("VER")), "\r\n"});
    expectCmd("R2", "VER");
  endtask

  task automatic testLowerHex();
    sendText({"ERRLOG:", $sformatf("%02x", sumOf("ERRLOG")), "\r\n"});
    expectCmd("R4", "ERRLOG");
  endtask

  task automatic testMismatch();
    sendText("DATE:00\r\n");
    expectErr("R5", 1'b0);
    // R3: name from previous good line is held
    check("R3", "held name", 128'(cmdName), packName("ERRLOG"));
  endtask

  task automatic testMalformed();
    sendText("VER\r\n");        expectErr("R6", 1'b0);
    sendText("VER:E\r\n");      expectErr("R6", 1'b0);
    sendText("VER:EDD\r\n");    expectErr("R6", 1'b0);
    sendText("VER:EG\r\n");     expectErr("R4", 1'b0);
    sendText("VER:E:D\r\n");    expectErr("R4", 1'b0);
    sendText("\r\n");           expectErr("R6", 1'b0);
  endtask

  task automatic testLengthLimit();
    string full = "ABCDEFGHIJKLMNOP";
    string over = "ABCDEFGHIJKLMNOPQ";
    sendText({full, ":", $sformatf("%02X", sumOf(full)), "\r\n"});
    expectCmd("R7", full);
    sendText({over, ":", $sformatf("%02X", sumOf(over)), "\r\n"});
    expectErr("R7", 1'b1);
    // R10: short name after long one, upper bytes zero
    sendText("VER:ED\r\n");
    expectCmd("R10", "VER");
  endtask

  task automatic testTerminators();
    sendText("VER:ED\n");
    expectCmd("R8", "VER");
    sendText("V\rER:E\rD\r\r\n");
    expectCmd("R8", "VER");
  endtask

  task automatic testValidGate();
    // R1: garbage on rxData with rxValid low between bytes
    string s = "VER:ED\r\n";
    for (int k = 0; k < s.len(); k++) begin
      sendByte(8'(s[k]));
      if (k + 1 < s.len()) begin
        rxData = 8'h0A;
        @(negedge clk);
        check("R1", "no strobe while idle", 128'(cmdValid | errValid), 128'd0);
        rxData = 8'h3A;
        @(negedge clk);
      end
    end
    expectCmd("R1", "VER");
  endtask

  task automatic testRecovery();
    // R10: a bad line with carried-over sum must not taint the next line
    sendText("ZZZZ:11\r\n");
    expectErr("R10", 1'b0);
    sendText("DATE:1E\r\n");
    expectCmd("R10", "DATE");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testGoodUpper();
    testLowerHex();
    testMismatch();
    testMalformed();
    testLengthLimit();
    testTerminators();
    testValidGate();
    testRecovery();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule